// File: doc/BRIEF.md
# Multi-Port Debursting Buffer with Chained Readout

This block soaks up a burst that arrives on many parallel write ports at once and lets a single reader drain it at its own pace, in its own clock domain. Every write port owns a private memory bank. The reader sees all banks as one flat address space. The upper field of the read address names a bank and the lower field names a word inside that bank.

Read data is not gathered by a wide multiplexer or an OR tree. A read request, address and enable enter bank 0 and advance one bank per read-clock cycle. Each bank places its word on the chain only when it is the addressed bank and drives zeros otherwise. A registered OR stage next to each bank folds that bank's output into a running result. The merged word leaves the last stage. The reader gets a fixed latency equal to the bank count and can issue one request on every cycle. The writer is responsible for never writing a word while that word is being read, because the write ports carry no added delay.

Top module: `deburst_buffer`

## Requirements
- R1: A write on port k with address a, sampled on a rising `wr_clk` edge while `wr_en[k]` is high, changes only word a of bank k. Reads of every other bank at address a still return the words held there before.
- R2: `rd_addr` is `{bank, word}`. The bank field is the top `BANK_W` bits and the word field is the low `WORD_W` bits. A valid read returns the word most recently written to that word of that bank.
- R3: If `rd_en` is sampled high on read-clock edge e, then `rd_valid` is high and `rd_data` carries the result right after edge e+`N_BANKS`. The pulse lasts exactly one cycle.
- R4: Requests on consecutive read-clock cycles are all accepted. Each returns its own word, in request order, on consecutive cycles.
- R5: `rd_data` is all zeros on every read cycle where `rd_valid` is low.
- R6: A read whose bank field is `N_BANKS` or larger returns all-zero data, and `rd_valid` is still asserted on the R3 schedule.
- R7: `rd_rst` is synchronous to `rd_clk` and active high. It drops every request still in flight. After a reset edge `rd_valid` is low and `rd_data` is zero, and both stay that way until a request made after the reset reaches the output.
- R8: All write ports may write on the same `wr_clk` edge, each to its own bank. `wr_clk` runs independently of `rd_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock shared by all write ports |
| wr_en | input | N_BANKS | Per-port write enable, bit k for bank k |
| wr_addr | input | N_BANKS*WORD_W | Per-port word address, slice k for bank k |
| wr_data | input | N_BANKS*DATA_W | Per-port write data, slice k for bank k |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset of the read pipeline |
| rd_en | input | 1 | Read request |
| rd_addr | input | BANK_W+WORD_W | Read address {bank, word} |
| rd_valid | output | 1 | Read result valid, N_BANKS cycles after the request |
| rd_data | output | DATA_W | Read result, zero when not valid |

## Verification
Each read result is due `N_BANKS` read-clock cycles after the edge that samples the request. That is one cycle for bank 0's registered read plus one per OR stage, with bank 0's read overlapping the first stage. The bench model records every sampled request in a queue that is preloaded with `N_BANKS` idle entries after each reset edge. On each read-clock edge it pops the entry that falls due, and the ports are compared against that entry at the following falling edge. Writes take effect on the next rising `wr_clk` edge. The bench keeps write phases apart from read phases, so no read ever observes a word in the middle of being written. A separate check counts the cycles from an isolated request to `rd_valid`.

// File: rtl/deburst_pkg.sv
package deburst_pkg;

  // Bits needed to index n items, at least one.
  function automatic int field_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/deburst_bank.sv
// One write port's private bank. The read port is zero-gated: the
// registered output is all zeros unless this bank is addressed.
module deburst_bank #(
  parameter int DATA_W  = 300,
  parameter int DEPTH   = 16,
  parameter int BANK_ID = 0,
  parameter int BANK_W  = 5,
  parameter int WORD_W  = 4
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [WORD_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              hit;

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_word] <= wr_data;
  end

  assign hit = rd_en && (rd_bank == BANK_W'(BANK_ID));

  always_ff @(posedge rd_clk) begin
    if (rd_rst)   rd_q <= '0;
    else if (hit) rd_q <= mem[rd_word];
    else          rd_q <= '0;
  end

endmodule

// File: rtl/deburst_stage.sv
// One link of the readout chain: forwards the request enable and
// folds one bank's gated output into the running result.
module deburst_stage #(
  parameter int DATA_W = 300
) (
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              en_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] bank_q,
  output logic              en_out,
  output logic [DATA_W-1:0] acc_out
);

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      en_out  <= 1'b0;
      acc_out <= '0;
    end else begin
      en_out  <= en_in;
      acc_out <= acc_in | bank_q;
    end
  end

endmodule

// File: rtl/deburst_buffer.sv
module deburst_buffer
  import deburst_pkg::*;
#(
  parameter int N_BANKS = 20,
  parameter int DATA_W  = 300,
  parameter int DEPTH   = 16,
  localparam int WORD_W = field_w(DEPTH),
  localparam int BANK_W = field_w(N_BANKS),
  localparam int ADDR_W = BANK_W + WORD_W
) (
  input  logic                        wr_clk,
  input  logic [N_BANKS-1:0]          wr_en,
  input  logic [N_BANKS*WORD_W-1:0]   wr_addr,
  input  logic [N_BANKS*DATA_W-1:0]   wr_data,
  input  logic                        rd_clk,
  input  logic                        rd_rst,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data
);

  // Request address as seen by each bank, one cycle later per bank.
  logic [ADDR_W-1:0] addr_p [N_BANKS];
  // Request enable along the chain; index N_BANKS leaves the last stage.
  logic [N_BANKS:0]  en_p;
  // Running OR result; index 0 is the empty seed.
  logic [DATA_W-1:0] acc_p  [N_BANKS+1];
  // Gated bank outputs.
  logic [DATA_W-1:0] bank_q [N_BANKS];
  logic              valid_q;

  assign addr_p[0] = rd_addr;
  assign en_p[0]   = rd_en;
  assign acc_p[0]  = '0;

  for (genvar k = 0; k < N_BANKS; k++) begin : g_chain
    deburst_bank #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .BANK_ID(k),
      .BANK_W (BANK_W),
      .WORD_W (WORD_W)
    ) u_bank (
      .wr_clk (wr_clk),
      .wr_en  (wr_en[k]),
      .wr_word(wr_addr[k*WORD_W +: WORD_W]),
      .wr_data(wr_data[k*DATA_W +: DATA_W]),
      .rd_clk (rd_clk),
      .rd_rst (rd_rst),
      .rd_en  (en_p[k]),
      .rd_bank(addr_p[k][ADDR_W-1 -: BANK_W]),
      .rd_word(addr_p[k][WORD_W-1:0]),
      .rd_q   (bank_q[k])
    );

    deburst_stage #(
      .DATA_W(DATA_W)
    ) u_stage (
      .rd_clk (rd_clk),
      .rd_rst (rd_rst),
      .en_in  (en_p[k]),
      .acc_in (acc_p[k]),
      .bank_q (bank_q[k]),
      .en_out (en_p[k+1]),
      .acc_out(acc_p[k+1])
    );

    if (k < N_BANKS - 1) begin : g_fwd
      always_ff @(posedge rd_clk) begin
        if (rd_rst) addr_p[k+1] <= '0;
        else        addr_p[k+1] <= addr_p[k];
      end
    end
  end

  // The last OR stage lands one cycle after the last enable hop.
  always_ff @(posedge rd_clk) begin
    if (rd_rst) valid_q <= 1'b0;
    else        valid_q <= en_p[N_BANKS];
  end

  assign rd_valid = valid_q;
  assign rd_data  = acc_p[N_BANKS];

endmodule

// File: rtl/deburst_buffer_chk.sv
module deburst_buffer_chk #(
  parameter int N_BANKS = 20,
  parameter int DATA_W  = 300,
  parameter int BANK_W  = 5,
  parameter int ADDR_W  = 9
) (
  input logic              rd_clk,
  input logic              rd_rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);

  logic [N_BANKS:0] req_sh;
  logic [N_BANKS:0] oor_sh;
  logic             oor_now;

  assign oor_now = rd_en && (int'(rd_addr[ADDR_W-1 -: BANK_W]) >= N_BANKS);

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      req_sh <= '0;
      oor_sh <= '0;
    end else begin
      req_sh <= {req_sh[N_BANKS-1:0], rd_en};
      oor_sh <= {oor_sh[N_BANKS-1:0], oor_now};
    end
  end

  p_valid_sched_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_valid == req_sh[N_BANKS]);

  p_idle_zero_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_valid |-> (rd_data == '0));

  p_oor_zero_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    oor_sh[N_BANKS] |-> (rd_valid && (rd_data == '0)));

  p_reset_clear_r7: assert property (@(posedge rd_clk)
    rd_rst |=> (!rd_valid && (rd_data == '0)));

endmodule

bind deburst_buffer deburst_buffer_chk #(
  .N_BANKS(N_BANKS),
  .DATA_W (DATA_W),
  .BANK_W (BANK_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .rd_clk  (rd_clk),
  .rd_rst  (rd_rst),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .rd_valid(rd_valid),
  .rd_data (rd_data)
);

// File: tb/sim_deburst_buffer.sv
module sim_deburst_buffer;

  localparam int N   = 20;
  localparam int W   = 300;
  localparam int D   = 16;
  localparam int WB  = 4;
  localparam int BB  = 5;
  localparam int AW  = BB + WB;
  localparam int LAT = N;

  logic              wr_clk = 1'b0;
  logic              rd_clk = 1'b0;
  logic [N-1:0]      wr_en  = '0;
  logic [N*WB-1:0]   wr_addr = '0;
  logic [N*W-1:0]    wr_data = '0;
  logic              rd_rst = 1'b1;
  logic              rd_en  = 1'b0;
  logic [AW-1:0]     rd_addr = '0;
  logic              rd_valid;
  logic [W-1:0]      rd_data;

  always #5 rd_clk = ~rd_clk;   // 100 MHz read clock
  always #3 wr_clk = ~wr_clk;   // unrelated write clock

  deburst_buffer #(.N_BANKS(N), .DATA_W(W), .DEPTH(D)) u0 (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_checks = 0;
  int n_errors = 0;
  int rcyc = 0;
  bit started = 1'b0;
  string cur_tag = "R7";

  logic [W-1:0] mdl [N][D];

  bit           qv [$];
  logic [W-1:0] qd [$];
  string        qt [$];
  bit           exp_v = 1'b0;
  logic [W-1:0] exp_d = '0;
  string        exp_t = "R7";

  function automatic logic [W-1:0] pat(input int b, input int w, input int s);
    logic [W-1:0] v;
    int unsigned h;
    h = 32'(b * 1000003 + w * 7919 + s * 104729 + 12345);
    for (int i = 0; i < W; i++) begin
      h = h * 32'd1103515245 + 32'd12345;
      v[i] = h[16];
    end
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // Reference model: record each sampled request, pop the one due now.
  always @(posedge rd_clk) begin
    rcyc <= rcyc + 1;
    if (rd_rst) begin
      started = 1'b1;
      qv.delete(); qd.delete(); qt.delete();
      for (int i = 0; i < LAT; i++) begin
        qv.push_back(1'b0); qd.push_back('0); qt.push_back("R7");
      end
      exp_v = 1'b0; exp_d = '0; exp_t = "R7";
    end else if (started) begin
      int b;
      int w;
      b = int'(rd_addr[AW-1 -: BB]);
      w = int'(rd_addr[WB-1:0]);
      if (rd_en) begin
        qv.push_back(1'b1);
        qd.push_back((b < N) ? mdl[b][w] : '0);
        qt.push_back(cur_tag);
      end else begin
        qv.push_back(1'b0); qd.push_back('0); qt.push_back(cur_tag);
      end
      exp_v = qv.pop_front();
      exp_d = qd.pop_front();
      exp_t = qt.pop_front();
    end
  end

  always @(negedge rd_clk) begin
    if (started) begin
      string t;
      t = exp_v ? exp_t : ((exp_t == "R7") ? "R7" : "R5");
      check(rd_valid === exp_v, t, "rd_valid", W'(rd_valid), W'(exp_v));
      check(rd_data === exp_d, t, "rd_data", rd_data, exp_d);
    end
  end

  task automatic write_all(input int word, input int salt);
    @(negedge wr_clk);
    for (int k = 0; k < N; k++) begin
      wr_en[k] = 1'b1;
      wr_addr[k*WB +: WB] = WB'(word);
      wr_data[k*W +: W] = pat(k, word, salt);
      mdl[k][word] = pat(k, word, salt);
    end
    @(negedge wr_clk);
    wr_en = '0;
  endtask

  task automatic write_one(input int port, input int word, input int salt);
    @(negedge wr_clk);
    wr_en[port] = 1'b1;
    wr_addr[port*WB +: WB] = WB'(word);
    wr_data[port*W +: W] = pat(port, word, salt);
    mdl[port][word] = pat(port, word, salt);
    @(negedge wr_clk);
    wr_en = '0;
  endtask

  task automatic rd(input int bank, input int word);
    @(negedge rd_clk);
    rd_en = 1'b1;
    rd_addr = {BB'(bank), WB'(word)};
  endtask

  task automatic rd_idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge rd_clk);
      rd_en = 1'b0;
    end
  endtask

  initial begin
    repeat (50000) @(posedge rd_clk);
    n_errors++;
    $display("FAIL R3 watchdog: actual %0d cycles expected fewer", rcyc);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int t0;
    int lat;
    // R7: reset state
    rd_rst = 1'b1;
    repeat (3) @(negedge rd_clk);
    check(rd_valid === 1'b0, "R7", "valid in reset", W'(rd_valid), '0);
    check(rd_data === '0, "R7", "data in reset", rd_data, '0);
    rd_rst = 1'b0;

    // R8: every port writes on the same edge, word by word
    for (int w = 0; w < D; w++) write_all(w, 1);

    // R8 / R2: sweep the whole space back to back
    cur_tag = "R8";
    for (int b = 0; b < N; b++)
      for (int w = 0; w < D; w++) rd(b, w);
    rd_idle(LAT + 2);

    // R3: isolated request, count cycles to valid
    cur_tag = "R3";
    @(negedge rd_clk);
    rd_en = 1'b1; rd_addr = {BB'(7), WB'(9)};
    t0 = rcyc + 1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    while (!rd_valid && (rcyc - t0) < 4 * LAT) @(negedge rd_clk);
    lat = rcyc - t0;
    check(lat == LAT, "R3", "latency", W'(lat), W'(LAT));
    @(negedge rd_clk);
    check(rd_valid === 1'b0, "R3", "pulse width", W'(rd_valid), '0);
    rd_idle(LAT + 2);

    // R1: one port overwrites a word; other banks keep theirs
    write_one(5, 3, 2);
    write_one(5, 3, 3);
    cur_tag = "R1";
    for (int b = 0; b < N; b++) rd(b, 3);
    rd_idle(LAT + 2);

    // R2 / R4: scattered addresses, back to back, descending and mixed
    cur_tag = "R4";
    for (int i = 0; i < 60; i++) rd((i * 7) % N, (i * 5 + 3) % D);
    cur_tag = "R2";
    for (int i = 0; i < 20; i++) rd(N - 1 - i, 15 - (i % D));
    rd_idle(LAT + 2);

    // R6: out-of-range bank field interleaved with valid reads
    cur_tag = "R6";
    for (int i = 0; i < 24; i++) begin
      if (i % 2 == 0) rd(N + (i / 2) % (32 - N), i % D);
      else            rd(i % N, i % D);
    end
    rd(31, 15);
    rd(N, 0);
    rd_idle(LAT + 2);

    // R7: reset in the middle of a burst drops everything in flight
    cur_tag = "R4";
    for (int i = 0; i < 10; i++) rd(i, i);
    @(negedge rd_clk);
    rd_rst = 1'b1;
    rd_en = 1'b1; rd_addr = {BB'(2), WB'(2)};
    @(negedge rd_clk);
    rd_rst = 1'b0;
    rd_en = 1'b0;
    cur_tag = "R7";
    rd_idle(LAT + 2);
    cur_tag = "R4";
    for (int i = 0; i < 8; i++) rd(N - 1 - i, i);
    rd_idle(LAT + 4);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule